// File: doc/BRIEF.md
# Indirect Auto-Increment Access Window

This block lets a host reach a large internal memory and a peripheral register space through eight host-visible registers. For the memory side, the host first loads a read pointer or a write pointer. It then reads or writes a memory data register as many times as it needs. Each data access completes one dword transfer on the internal memory port and moves the pointer it used forward by one dword. The read pointer and the write pointer are separate, so a read stream and a write stream can be interleaved without disturbing each other.

The peripheral side uses the same idea, with its own write-address, read-address, write-data and read-data registers. A peripheral address register holds two fields. Bits 15:0 are the register offset. Bits 25:24 are the transfer size in bytes minus one, so a value of 3 means a full dword. The size becomes byte enables for the lowest bytes of the word. Peripheral addresses never advance.

A host access stays pending until the block pulses its acknowledge. For a data-register access that pulse comes only after the internal transfer has completed, so a read returns the fetched word.

Top module: `idx_access_window`

## Requirements
- R1: After reset, host_ack, mem_req_valid and per_req are low, host_rdata is zero, and both memory pointers read back as zero.
- R2: Writing a memory pointer register (select 0 for the read pointer, select 1 for the write pointer) stores the address with bits 1:0 forced to zero. Reading the register returns the stored value.
- R3: Each host write to select 2 issues one memory write of that data at the write pointer and then advances the write pointer by 4. The pointer wraps from 0xFFFFFFFC to 0.
- R4: Each host read of select 3 issues one memory read at the read pointer. The host acknowledge is withheld until mem_rsp_valid arrives, host_rdata returns mem_rsp_data, and the read pointer then advances by 4.
- R5: Read and write pointers advance independently, so alternating reads and writes each follow their own sequence.
- R6: While mem_req_valid is high and mem_req_ready is low, the request (valid, address, direction) is held unchanged, and each host data access produces exactly one accepted request.
- R7: Writing a peripheral address register (select 4 for write, select 5 for read) keeps bits 15:0 as the offset and bits 25:24 as the size. A read of the register returns only those fields, with all other bits zero.
- R8: A host write to select 6 drives per_req with per_we high, the write offset, the data, and per_be set for the lowest N bytes, where N is the size field plus 1.
- R9: A host read of select 7 drives a peripheral read at the read offset and returns per_rdata after per_ack. Peripheral addresses do not change after accesses.
- R10: host_ack is a single-cycle pulse for each host access.
- R11: A write to a read-data register (select 3 or 7) starts no internal access and changes no pointer. A read of a write-data register (select 2 or 6) returns zero and starts no internal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ack |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_sel | input | 3 | Host register select (0 to 7) |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle access completion pulse |
| host_rdata | output | 32 | Host read data, valid with host_ack |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory byte address, dword aligned |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| per_req | output | 1 | Peripheral request, held until per_ack |
| per_we | output | 1 | Peripheral request is a write |
| per_addr | output | 16 | Peripheral register offset |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_ack | input | 1 | Peripheral access complete |
| per_rdata | input | 32 | Peripheral read data |

## Verification
A pointer that advances at the wrong time shows up at the very next data access of the same stream, as a wrong mem_req_addr or a wrong returned word. It also shows up at once when the pointer register is read back. If the two streams shared state, the interleaved sequence would expose it within two accesses. A controller that acknowledges a read too early returns stale host_rdata on that same access. A wrong size decode shows up on per_be in the cycle the peripheral request is issued.

// File: rtl/iaw_pkg.sv
// Shared definitions for the indirect access window.
// Assumes the host selects one of eight registers with a 3-bit code.
package iaw_pkg;
    typedef enum logic [2:0] {
        SEL_MEM_RPTR  = 3'd0,
        SEL_MEM_WPTR  = 3'd1,
        SEL_MEM_WDATA = 3'd2,
        SEL_MEM_RDATA = 3'd3,
        SEL_PER_WADR  = 3'd4,
        SEL_PER_RADR  = 3'd5,
        SEL_PER_WDATA = 3'd6,
        SEL_PER_RDATA = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_REQ,
        ST_MEM_RSP,
        ST_PER_REQ,
        ST_DONE
    } fsm_e;
endpackage

// File: rtl/iaw_dword_ptr.sv
// Dword pointer with load and advance-by-one-dword.
// Stores only the bits above the byte offset, so the low bits always read as zero.
// Assumes load and advance are never requested in the same cycle (load wins).
module iaw_dword_ptr #(
    parameter int AW  = 32,
    parameter int LSB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:LSB] load_val_i,
    input  logic          adv_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:LSB] hi_q;

    // Pointer register: load from host, or step one dword.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (load_i) hi_q <= load_val_i;
        else if (adv_i)  hi_q <= hi_q + 1'b1;
    end

    assign ptr_o = {hi_q, {LSB{1'b0}}};
endmodule

// File: rtl/iaw_per_addr.sv
// Peripheral address register: holds an offset and a size (bytes minus one).
// It decodes the size into byte enables for the lowest bytes and builds the readback word.
// Assumes SIZE_LSB + SZ_W <= DATA_W and OFS_W <= SIZE_LSB.
module iaw_per_addr #(
    parameter int DATA_W   = 32,
    parameter int OFS_W    = 16,
    parameter int SIZE_LSB = 24,
    localparam int BYTES   = DATA_W / 8,
    localparam int SZ_W    = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [OFS_W-1:0]  ofs_val_i,
    input  logic [SZ_W-1:0]   size_val_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [BYTES-1:0]  be_o,
    output logic [DATA_W-1:0] rdback_o
);
    logic [OFS_W-1:0] ofs_q;
    logic [SZ_W-1:0]  size_q;

    // Field storage, written whole on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            size_q <= '0;
        end else if (load_i) begin
            ofs_q  <= ofs_val_i;
            size_q <= size_val_i;
        end
    end

    // One enable per byte lane: lane i is on when i <= size.
    for (genvar i = 0; i < BYTES; i++) begin : g_be
        assign be_o[i] = (SZ_W'(i) <= size_q);
    end

    // Readback word: offset and size in place, other bits zero.
    always_comb begin
        rdback_o = '0;
        rdback_o[OFS_W-1:0] = ofs_q;
        rdback_o[SIZE_LSB +: SZ_W] = size_q;
    end

    assign ofs_o = ofs_q;
endmodule

// File: rtl/iaw_ctrl.sv
// Host access sequencer. It decodes the selected register and runs one internal
// memory or peripheral transfer for data registers, then pulses the acknowledge.
// Assumes the host holds its request stable until the acknowledge and
// drops it before the cycle after the acknowledge.
module iaw_ctrl
    import iaw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [2:0]        host_sel_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_ack_o,
    output logic [DATA_W-1:0] host_rdata_o,
    input  logic [MEM_AW-1:0] rptr_i,
    input  logic [MEM_AW-1:0] wptr_i,
    input  logic [DATA_W-1:0] per_wa_rb_i,
    input  logic [DATA_W-1:0] per_ra_rb_i,
    output logic              rptr_load_o,
    output logic              wptr_load_o,
    output logic              rptr_adv_o,
    output logic              wptr_adv_o,
    output logic              per_wa_load_o,
    output logic              per_ra_load_o,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              per_req_o,
    input  logic              per_ack_i,
    input  logic [DATA_W-1:0] per_rdata_i,
    output logic              op_we_o,
    output logic [DATA_W-1:0] wdata_o
);
    fsm_e              state_q;
    logic              op_we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    reg_sel_e          sel;
    logic              take;

    assign sel  = reg_sel_e'(host_sel_i);
    assign take = (state_q == ST_IDLE) && host_req_i;

    // Register-write strobes, issued in the cycle a request is taken.
    always_comb begin
        rptr_load_o   = take && host_we_i && (sel == SEL_MEM_RPTR);
        wptr_load_o   = take && host_we_i && (sel == SEL_MEM_WPTR);
        per_wa_load_o = take && host_we_i && (sel == SEL_PER_WADR);
        per_ra_load_o = take && host_we_i && (sel == SEL_PER_RADR);
        wptr_adv_o    = (state_q == ST_MEM_REQ) && mem_ready_i && op_we_q;
        rptr_adv_o    = (state_q == ST_MEM_RSP) && mem_rsp_valid_i;
    end

    // Sequencer: decode, run the internal transfer, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_we_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (host_req_i) begin
                    op_we_q <= host_we_i;
                    rdata_q <= '0;
                    state_q <= ST_DONE;
                    unique case (sel)
                        SEL_MEM_RPTR:  if (!host_we_i) rdata_q <= DATA_W'(rptr_i);
                        SEL_MEM_WPTR:  if (!host_we_i) rdata_q <= DATA_W'(wptr_i);
                        SEL_PER_WADR:  if (!host_we_i) rdata_q <= per_wa_rb_i;
                        SEL_PER_RADR:  if (!host_we_i) rdata_q <= per_ra_rb_i;
                        SEL_MEM_WDATA: if (host_we_i) begin
                            wdata_q <= host_wdata_i;
                            state_q <= ST_MEM_REQ;
                        end
                        SEL_MEM_RDATA: if (!host_we_i) state_q <= ST_MEM_REQ;
                        SEL_PER_WDATA: if (host_we_i) begin
                            wdata_q <= host_wdata_i;
                            state_q <= ST_PER_REQ;
                        end
                        SEL_PER_RDATA: if (!host_we_i) state_q <= ST_PER_REQ;
                        default: ;
                    endcase
                end
                ST_MEM_REQ: if (mem_ready_i) state_q <= op_we_q ? ST_DONE : ST_MEM_RSP;
                ST_MEM_RSP: if (mem_rsp_valid_i) begin
                    rdata_q <= mem_rsp_data_i;
                    state_q <= ST_DONE;
                end
                ST_PER_REQ: if (per_ack_i) begin
                    if (!op_we_q) rdata_q <= per_rdata_i;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign host_ack_o   = (state_q == ST_DONE);
    assign host_rdata_o = rdata_q;
    assign mem_valid_o  = (state_q == ST_MEM_REQ);
    assign per_req_o    = (state_q == ST_PER_REQ);
    assign op_we_o      = op_we_q;
    assign wdata_o      = wdata_q;

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_o |=> !host_ack_o);
    // R4
    rd_ack_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM_RSP) && !mem_rsp_valid_i |=> !host_ack_o);
endmodule

// File: rtl/idx_access_window.sv
// Indirect access window: eight host registers give pointer-based access to an
// internal memory (separate auto-advancing read/write dword pointers) and to a
// peripheral space (offset plus byte count). Assumes MEM_AW <= DATA_W.
module idx_access_window #(
    parameter int DATA_W    = 32,
    parameter int MEM_AW    = 32,
    parameter int PER_OFS_W = 16,
    parameter int SIZE_LSB  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [2:0]           host_sel,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic                 host_ack,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_we,
    output logic [MEM_AW-1:0]    mem_req_addr,
    output logic [DATA_W-1:0]    mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [DATA_W-1:0]    mem_rsp_data,
    output logic                 per_req,
    output logic                 per_we,
    output logic [PER_OFS_W-1:0] per_addr,
    output logic [DATA_W/8-1:0]  per_be,
    output logic [DATA_W-1:0]    per_wdata,
    input  logic                 per_ack,
    input  logic [DATA_W-1:0]    per_rdata
);
    import iaw_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam int LSB   = $clog2(BYTES);
    localparam int SZ_W  = $clog2(BYTES);

    logic              rptr_load, wptr_load, rptr_adv, wptr_adv;
    logic              wa_load, ra_load, op_we;
    logic [MEM_AW-1:0] rptr, wptr;
    logic [PER_OFS_W-1:0] wa_ofs, ra_ofs;
    logic [BYTES-1:0]  wa_be, ra_be;
    logic [DATA_W-1:0] wa_rb, ra_rb, wdata;

    iaw_dword_ptr #(.AW(MEM_AW), .LSB(LSB)) u_rptr (
        .clk(clk), .rst_n(rst_n), .load_i(rptr_load),
        .load_val_i(host_wdata[MEM_AW-1:LSB]), .adv_i(rptr_adv), .ptr_o(rptr));

    iaw_dword_ptr #(.AW(MEM_AW), .LSB(LSB)) u_wptr (
        .clk(clk), .rst_n(rst_n), .load_i(wptr_load),
        .load_val_i(host_wdata[MEM_AW-1:LSB]), .adv_i(wptr_adv), .ptr_o(wptr));

    iaw_per_addr #(.DATA_W(DATA_W), .OFS_W(PER_OFS_W), .SIZE_LSB(SIZE_LSB)) u_per_wa (
        .clk(clk), .rst_n(rst_n), .load_i(wa_load),
        .ofs_val_i(host_wdata[PER_OFS_W-1:0]), .size_val_i(host_wdata[SIZE_LSB +: SZ_W]),
        .ofs_o(wa_ofs), .be_o(wa_be), .rdback_o(wa_rb));

    iaw_per_addr #(.DATA_W(DATA_W), .OFS_W(PER_OFS_W), .SIZE_LSB(SIZE_LSB)) u_per_ra (
        .clk(clk), .rst_n(rst_n), .load_i(ra_load),
        .ofs_val_i(host_wdata[PER_OFS_W-1:0]), .size_val_i(host_wdata[SIZE_LSB +: SZ_W]),
        .ofs_o(ra_ofs), .be_o(ra_be), .rdback_o(ra_rb));

    iaw_ctrl #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_req_i(host_req), .host_we_i(host_we), .host_sel_i(host_sel),
        .host_wdata_i(host_wdata), .host_ack_o(host_ack), .host_rdata_o(host_rdata),
        .rptr_i(rptr), .wptr_i(wptr), .per_wa_rb_i(wa_rb), .per_ra_rb_i(ra_rb),
        .rptr_load_o(rptr_load), .wptr_load_o(wptr_load),
        .rptr_adv_o(rptr_adv), .wptr_adv_o(wptr_adv),
        .per_wa_load_o(wa_load), .per_ra_load_o(ra_load),
        .mem_valid_o(mem_req_valid), .mem_ready_i(mem_req_ready),
        .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
        .per_req_o(per_req), .per_ack_i(per_ack), .per_rdata_i(per_rdata),
        .op_we_o(op_we), .wdata_o(wdata));

    // Port steering: the direction of the current operation picks the address source.
    assign mem_req_we    = op_we;
    assign mem_req_addr  = op_we ? wptr : rptr;
    assign mem_req_wdata = wdata;
    assign per_we        = op_we;
    assign per_addr      = op_we ? wa_ofs : ra_ofs;
    assign per_be        = op_we ? wa_be : ra_be;
    assign per_wdata     = wdata;

    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
    // R2
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[LSB-1:0] == '0));
    // R5
    rptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr != $past(rptr)) |->
            $past(mem_rsp_valid) || $past(host_req && host_we && host_sel == SEL_MEM_RPTR));
    // R8
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> per_be[0] && ((per_be & (per_be + 1'b1)) == '0));
endmodule

// File: tb/idx_access_window_bench.sv
module idx_access_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        per_req, per_we;
    logic [15:0] per_addr;
    logic [3:0]  per_be;
    logic [31:0] per_wdata;
    logic        per_ack = 1'b0;
    logic [31:0] per_rdata = '0;

    int n_chk = 0, n_err = 0, last_lat = 0;
    logic [31:0] mem [0:63];
    logic [31:0] pregs [0:15];
    int mem_wr_cnt = 0, mem_rd_cnt = 0, per_cnt = 0, cyc = 0;
    logic stall_en = 1'b0, rsp_pend = 1'b0;
    int rsp_cnt = 0;
    logic [5:0] rsp_idx = '0;
    logic [15:0] last_paddr;
    logic [3:0]  last_pbe;
    logic        last_pwe;
    logic [31:0] last_pwdata;

    always #2 clk = ~clk;

    idx_access_window u_idx_access_window (.*);

    // Memory model: ready pattern, then accept, fixed read latency.
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rsp_pend) begin
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[rsp_idx];
                rsp_pend      = 1'b0;
            end else rsp_cnt--;
        end
        mem_req_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr[7:2]] = mem_req_wdata;
                mem_wr_cnt++;
            end else begin
                rsp_pend = 1'b1; rsp_cnt = 2; rsp_idx = mem_req_addr[7:2];
                mem_rd_cnt++;
            end
        end
    end

    // Peripheral model: one-cycle ack, byte-enable merge.
    always @(negedge clk) begin
        if (per_ack) per_ack = 1'b0;
        else if (per_req) begin
            last_paddr = per_addr; last_pbe = per_be; last_pwe = per_we; last_pwdata = per_wdata;
            if (per_we) begin
                for (int b = 0; b < 4; b++)
                    if (per_be[b]) pregs[per_addr[5:2]][8*b +: 8] = per_wdata[8*b +: 8];
            end else per_rdata = pregs[per_addr[5:2]];
            per_cnt++;
            per_ack = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_acc(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                            output logic [31:0] rd);
        host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = wd;
        last_lat = 0;
        do begin @(negedge clk); last_lat++; end while (!host_ack);
        rd = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        chk("R10 ack pulse", {31'b0, host_ack}, 32'h0);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
        logic [31:0] d;
        host_acc(1'b1, sel, wd, d);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        host_acc(1'b0, sel, 32'h0, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 host_ack", {31'b0, host_ack}, 0);
        chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 0);
        chk("R1 per_req", {31'b0, per_req}, 0);
        chk("R1 host_rdata", host_rdata, 0);
        rd(3'd0, d); chk("R1 rptr", d, 0);
        rd(3'd1, d); chk("R1 wptr", d, 0);
    endtask

    task automatic t_align();
        logic [31:0] d;
        wr(3'd1, 32'h1234_5677); rd(3'd1, d); chk("R2 wptr align", d, 32'h1234_5674);
        wr(3'd0, 32'h0000_0013); rd(3'd0, d); chk("R2 rptr align", d, 32'h0000_0010);
    endtask

    task automatic t_write_burst();
        logic [31:0] d;
        wr(3'd1, 32'h20);
        wr(3'd2, 32'hAAAA_0001); wr(3'd2, 32'hBBBB_0002); wr(3'd2, 32'hCCCC_0003);
        chk("R3 word0", mem[8], 32'hAAAA_0001);
        chk("R3 word1", mem[9], 32'hBBBB_0002);
        chk("R3 word2", mem[10], 32'hCCCC_0003);
        rd(3'd1, d); chk("R3 wptr after burst", d, 32'h2C);
    endtask

    task automatic t_read_burst();
        logic [31:0] d;
        int c0;
        wr(3'd0, 32'h20);
        rd(3'd3, d); chk("R4 read word0", d, 32'hAAAA_0001);
        chk("R4 stall latency", {31'b0, last_lat >= 5}, 1);
        stall_en = 1'b1;
        c0 = mem_rd_cnt;
        rd(3'd3, d); chk("R4 read word1", d, 32'hBBBB_0002);
        rd(3'd3, d); chk("R4 read word2", d, 32'hCCCC_0003);
        chk("R6 one request per access", mem_rd_cnt - c0, 2);
        stall_en = 1'b0;
        rd(3'd0, d); chk("R4 rptr after burst", d, 32'h2C);
    endtask

    task automatic t_interleave();
        logic [31:0] d;
        wr(3'd1, 32'h40); wr(3'd0, 32'h20);
        wr(3'd2, 32'h1111_1111);
        rd(3'd3, d); chk("R5 interleaved read0", d, 32'hAAAA_0001);
        wr(3'd2, 32'h2222_2222);
        rd(3'd3, d); chk("R5 interleaved read1", d, 32'hBBBB_0002);
        chk("R5 interleaved write0", mem[16], 32'h1111_1111);
        chk("R5 interleaved write1", mem[17], 32'h2222_2222);
        rd(3'd1, d); chk("R5 wptr", d, 32'h48);
        rd(3'd0, d); chk("R5 rptr", d, 32'h28);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(3'd1, 32'hFFFF_FFFC);
        wr(3'd2, 32'hD00D_0001); wr(3'd2, 32'hD00D_0002);
        chk("R3 top word", mem[63], 32'hD00D_0001);
        chk("R3 wrapped word", mem[0], 32'hD00D_0002);
        rd(3'd1, d); chk("R3 wptr wrap", d, 32'h4);
    endtask

    task automatic t_per_fields();
        logic [31:0] d;
        wr(3'd4, 32'hF2FF_1234); rd(3'd4, d); chk("R7 write addr fields", d, 32'h0200_1234);
        wr(3'd5, 32'hFDAA_0ABC); rd(3'd5, d); chk("R7 read addr fields", d, 32'h0100_0ABC);
    endtask

    task automatic t_per_write();
        logic [31:0] d;
        for (int s = 0; s < 4; s++) begin
            wr(3'd4, (32'(s) << 24) | 32'h8);
            wr(3'd6, 32'hA5A5_0000 + 32'(s));
            chk("R8 per_be", {28'b0, last_pbe}, (32'h1 << (s + 1)) - 1);
            chk("R8 per_addr", {16'b0, last_paddr}, 32'h8);
            chk("R8 per_we", {31'b0, last_pwe}, 1);
            chk("R8 per_wdata", last_pwdata, 32'hA5A5_0000 + 32'(s));
        end
        chk("R8 merged register", pregs[2], 32'hA5A5_0003);
        rd(3'd4, d); chk("R9 write addr not advanced", d, 32'h0300_0008);
    endtask

    task automatic t_per_read();
        logic [31:0] d;
        wr(3'd5, 32'h0300_000C);
        rd(3'd7, d); chk("R9 per read data", d, 32'h5A00_0000 ^ (3 * 32'h0101_0101));
        chk("R9 per_we low", {31'b0, last_pwe}, 0);
        rd(3'd7, d); chk("R9 repeat read same reg", {16'b0, last_paddr}, 32'hC);
        rd(3'd5, d); chk("R9 read addr not advanced", d, 32'h0300_000C);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        int r0, w0, p0;
        r0 = mem_rd_cnt; w0 = mem_wr_cnt; p0 = per_cnt;
        wr(3'd3, 32'hDEAD_BEEF);
        rd(3'd0, d); chk("R11 rptr unchanged", d, 32'h28);
        rd(3'd2, d); chk("R11 wdata reads zero", d, 0);
        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd6, d); chk("R11 per wdata reads zero", d, 0);
        chk("R11 no mem reads", mem_rd_cnt - r0, 0);
        chk("R11 no mem writes", mem_wr_cnt - w0, 0);
        chk("R11 no per access", per_cnt - p0, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) pregs[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_align();
        t_write_burst();
        t_read_burst();
        t_interleave();
        t_wrap();
        t_per_fields();
        t_per_write();
        t_per_read();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule